// File: doc/BRIEF.md
# Equivalent-Time Sampling Controller

This block rebuilds a waveform that repeats every pattern period. The period spans eight clock-edge positions of an external deserializer. An external delay line shifts the sampling instant in 32 fine steps. The controller walks the delay setting from the lowest tap to the highest. After each new setting it lets a programmable number of periods pass unused so that the delay can settle. It then counts, over a programmable number of periods, how often each of the eight edge positions sampled a one.

When the counting window for a tap closes, every edge position gets one of three classes. A position is stable low when no ones were seen. It is stable high when every sample was one. It is mixed when both values appeared, which places the point inside a transition's jitter zone. The pattern source and the sampler share one clock, so the sampling phase stays fixed from period to period. The eight edges and 32 taps together give 256 points about 78 ps apart.

The classes go into a result memory addressed by point index. Software or a neighbouring block reads them back after done rises. The counters are 20 bits wide, which covers a repetition count of one million.

Top module: `eqt_sampler`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` and `tap_load_o` are 0 and `tap_o` is 0.
- R2: A start pulse taken while idle or done begins a sweep. Taps are loaded in ascending order 0 to 31, each exactly once. Each load is announced by `tap_load_o` high for exactly one cycle, with `tap_o` already holding the new value. `tap_o` changes only in a load cycle.
- R3: After each tap load, the first `settle_i` cycles with `period_start_i` high are discarded. Their samples have no effect on the results.
- R4: The next N cycles with `period_start_i` high are counted. Bit k of `sample_i` in such a cycle adds to the one-count of edge position k. No count ever exceeds N.
- R5: Each result is a 2-bit code: 00 means no ones were counted, 01 means all N samples were one, 10 means anything in between. Code 11 is never produced.
- R6: The result for edge position k at tap t is stored at address k*32 + t. It appears on `rd_data_o` one cycle after `rd_addr_i` presents that address.
- R7: `done_o` rises after tap 31 has been classified and stays high until the next start. Results stay readable while it is high. `done_o` falls in the cycle after a start.
- R8: A start pulse that arrives while a sweep is running has no effect on the sweep or its results.
- R9: N is the value on `reps_i` captured at start. A value of 0 is treated as 1.
- R10: Samples offered with `period_start_i` outside the settle and counting windows are ignored. This covers the load cycle and the cycles spent storing results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the pattern source |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sweep (taken only while idle or done) |
| settle_i | input | 8 | Periods discarded after each tap load |
| reps_i | input | 20 | Periods counted per tap (N); 0 acts as 1 |
| period_start_i | input | 1 | Marks the cycle in which `sample_i` holds one period's samples |
| sample_i | input | 8 | One sample per edge position, bit k = edge k |
| tap_o | output | 5 | Delay tap to apply |
| tap_load_o | output | 1 | One-cycle strobe to load `tap_o` into the delay line |
| done_o | output | 1 | Sweep complete, results valid |
| rd_addr_i | input | 8 | Result address, edge*32 + tap |
| rd_data_o | output | 2 | Result code, one cycle after the address |

## Verification
The functions most likely to collide are period accounting and sequencing. A period marker can arrive in the very cycle a tap is loaded, or while the eight results of the previous tap are being stored. It can also arrive on the cycle where the settle window hands over to counting. The bench provokes this by asserting the marker every cycle in some sweeps and every third cycle in another. It feeds inverted, poisoning samples on every marker that falls outside the window the requirements define. A miscounted or misplaced period therefore turns a stable point into a mixed one. That error shows up when all 256 classes are read back and compared with values computed from the sample pattern. A start pulse is also injected in the middle of one sweep, to show that it does not disturb the sweep.

// File: rtl/eqt_pkg.sv
package eqt_pkg;

  typedef enum logic [1:0] {
    PT_LOW   = 2'b00,
    PT_HIGH  = 2'b01,
    PT_MIXED = 2'b10
  } pt_class_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_SETTLE,
    SQ_COUNT,
    SQ_WRITE,
    SQ_DONE
  } seq_state_e;

endpackage

// File: rtl/eqt_seq.sv
module eqt_seq
  import eqt_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int NUM_PH   = 8,
  parameter int CNT_W    = 20,
  parameter int SETTLE_W = 8,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int PH_W    = $clog2(NUM_PH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CNT_W-1:0]    reps_i,
  input  logic                period_start_i,
  output logic [TAP_W-1:0]    tap_o,
  output logic                tap_load_o,
  output logic                done_o,
  output logic                cnt_clr_o,
  output logic                cnt_en_o,
  output logic                cnt_active_o,
  output logic [CNT_W-1:0]    reps_lim_o,
  output logic                wr_en_o,
  output logic [PH_W-1:0]     wr_idx_o
);

  seq_state_e          state_q;
  logic [TAP_W-1:0]    tap_q;
  logic [SETTLE_W-1:0] settle_lim_q, settle_cnt_q;
  logic [CNT_W-1:0]    reps_lim_q, period_cnt_q;
  logic [PH_W-1:0]     wr_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SQ_IDLE;
      tap_q        <= '0;
      settle_lim_q <= '0;
      settle_cnt_q <= '0;
      reps_lim_q   <= CNT_W'(1);
      period_cnt_q <= '0;
      wr_idx_q     <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE, SQ_DONE: begin
          if (start_i) begin
            settle_lim_q <= settle_i;
            reps_lim_q   <= (reps_i == '0) ? CNT_W'(1) : reps_i;
            tap_q        <= '0;
            state_q      <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          settle_cnt_q <= '0;
          period_cnt_q <= '0;
          state_q      <= (settle_lim_q == '0) ? SQ_COUNT : SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (period_start_i) begin
            if (settle_cnt_q == settle_lim_q - SETTLE_W'(1)) state_q <= SQ_COUNT;
            else settle_cnt_q <= settle_cnt_q + SETTLE_W'(1);
          end
        end
        SQ_COUNT: begin
          if (period_start_i) begin
            if (period_cnt_q == reps_lim_q - CNT_W'(1)) begin
              wr_idx_q <= '0;
              state_q  <= SQ_WRITE;
            end else begin
              period_cnt_q <= period_cnt_q + CNT_W'(1);
            end
          end
        end
        SQ_WRITE: begin
          wr_idx_q <= wr_idx_q + PH_W'(1);
          if (wr_idx_q == PH_W'(NUM_PH - 1)) begin
            if (tap_q == TAP_W'(NUM_TAPS - 1)) begin
              state_q <= SQ_DONE;
            end else begin
              tap_q   <= tap_q + TAP_W'(1);
              state_q <= SQ_LOAD;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign tap_o        = tap_q;
  assign tap_load_o   = (state_q == SQ_LOAD);
  assign done_o       = (state_q == SQ_DONE);
  assign cnt_clr_o    = (state_q == SQ_LOAD);
  assign cnt_active_o = (state_q == SQ_COUNT);
  assign cnt_en_o     = (state_q == SQ_COUNT) && period_start_i;
  assign reps_lim_o   = reps_lim_q;
  assign wr_en_o      = (state_q == SQ_WRITE);
  assign wr_idx_o     = wr_idx_q;

  // R2: a load strobe lasts one cycle
  p_load_single_r2: assert property (@(posedge clk) disable iff (rst)
    tap_load_o |=> !tap_load_o);

  // R2: the tap value moves only together with a load strobe
  p_tap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tap_load_o |-> $stable(tap_o));

  // R7: done holds until a start arrives
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R8: a start during settling leaves the sequence alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SETTLE && start_i && !period_start_i) |=> (state_q == SQ_SETTLE));

endmodule

// File: rtl/eqt_ones_counters.sv
module eqt_ones_counters
  import eqt_pkg::*;
#(
  parameter int NUM_PH = 8,
  parameter int CNT_W  = 20,
  localparam int PH_W  = $clog2(NUM_PH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              active_i,
  input  logic [NUM_PH-1:0] sample_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic [PH_W-1:0]   sel_i,
  output pt_class_e         cls_o
);

  logic [CNT_W-1:0] ones_q [NUM_PH];

  for (genvar g = 0; g < NUM_PH; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr_i) ones_q[g] <= '0;
      else if (en_i && sample_i[g]) ones_q[g] <= ones_q[g] + CNT_W'(1);
    end

    // R4: no position counts more ones than periods counted
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
      active_i |-> (ones_q[g] <= lim_i));
  end

  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = ones_q[sel_i];

  always_comb begin
    if (sel_cnt == '0)        cls_o = PT_LOW;
    else if (sel_cnt == lim_i) cls_o = PT_HIGH;
    else                       cls_o = PT_MIXED;
  end

endmodule

// File: rtl/eqt_result_ram.sv
module eqt_result_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/eqt_sampler.sv
module eqt_sampler
  import eqt_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int NUM_PH   = 8,
  parameter int CNT_W    = 20,
  parameter int SETTLE_W = 8,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int PH_W    = $clog2(NUM_PH),
  localparam int NPTS    = NUM_TAPS * NUM_PH,
  localparam int ADDR_W  = $clog2(NPTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CNT_W-1:0]    reps_i,
  input  logic                period_start_i,
  input  logic [NUM_PH-1:0]   sample_i,
  output logic [TAP_W-1:0]    tap_o,
  output logic                tap_load_o,
  output logic                done_o,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [1:0]          rd_data_o
);

  logic             cnt_clr, cnt_en, cnt_active, wr_en;
  logic [CNT_W-1:0] reps_lim;
  logic [PH_W-1:0]  wr_idx;
  pt_class_e        cls;
  logic [1:0]       wr_data;

  eqt_seq #(
    .NUM_TAPS(NUM_TAPS), .NUM_PH(NUM_PH), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_i),
    .reps_i(reps_i), .period_start_i(period_start_i),
    .tap_o(tap_o), .tap_load_o(tap_load_o), .done_o(done_o),
    .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en), .cnt_active_o(cnt_active),
    .reps_lim_o(reps_lim), .wr_en_o(wr_en), .wr_idx_o(wr_idx)
  );

  eqt_ones_counters #(.NUM_PH(NUM_PH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .en_i(cnt_en),
    .active_i(cnt_active), .sample_i(sample_i), .lim_i(reps_lim),
    .sel_i(wr_idx), .cls_o(cls)
  );

  assign wr_data = cls;

  eqt_result_ram #(.DEPTH(NPTS), .DATA_W(2)) u_ram (
    .clk(clk), .we_i(wr_en), .waddr_i({wr_idx, tap_o}), .wdata_i(wr_data),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  // R5: the unused code is never stored
  p_class_code_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data != 2'b11));

  // R10: nothing is stored while a tap is being loaded
  p_no_write_on_load_r10: assert property (@(posedge clk) disable iff (rst)
    tap_load_o |-> !wr_en);

endmodule

// File: tb/eqt_sampler_bench.sv
module eqt_sampler_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] settle_i = '0;
  logic [19:0] reps_i = '0;
  logic       period_start_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic [4:0] tap_o;
  logic       tap_load_o, done_o;
  logic [7:0] rd_addr_i = '0;
  logic [1:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eqt_sampler u_eqt_sampler (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_i),
    .reps_i(reps_i), .period_start_i(period_start_i), .sample_i(sample_i),
    .tap_o(tap_o), .tap_load_o(tap_load_o), .done_o(done_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waveform: kind 0 always low, 1 always high, 2 high only in the first counted period
  function automatic logic [7:0] ideal(input int tap, input int c);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      int kind;
      kind = (k * 32 + tap) % 3;
      v[k] = (kind == 1) ? 1'b1 : ((kind == 2) ? (c == 0) : 1'b0);
    end
    return v;
  endfunction

  function automatic int exp_class(input int addr, input int n);
    int kind, ones;
    kind = addr % 3;
    ones = (kind == 0) ? 0 : ((kind == 1) ? n : 1);
    if (ones == 0) return 0;
    if (ones == n) return 1;
    return 2;
  endfunction

  task automatic run_sweep(input int s, input int reps, input int gap, input bit mid_start);
    int n, j, loads;
    bit fin;
    n = (reps == 0) ? 1 : reps;
    settle_i = 8'(s);
    reps_i = 20'(reps);
    j = 100000;
    loads = 0;
    fin = 1'b0;
    for (int cyc = 0; cyc < 30000; cyc++) begin
      @(negedge clk);
      if (cyc > 1 && done_o) begin fin = 1'b1; break; end
      if (cyc == 1) check(done_o == 1'b0, "R7 done low after start", int'(done_o), 0);
      start_i = (cyc == 0) || (mid_start && (cyc == 100 || cyc == 101));
      period_start_i = (gap == 1) || (cyc % gap == 0);
      if (tap_load_o) begin
        check(int'(tap_o) == loads, "R2 tap order", int'(tap_o), loads);
        loads++;
        j = 0;
        sample_i = ~ideal(int'(tap_o), 0);
      end else if (period_start_i) begin
        if (j >= s && j < s + n) sample_i = ideal(int'(tap_o), j - s);
        else sample_i = ~ideal(int'(tap_o), 0);  // R3 R10 poison
        j++;
      end else begin
        sample_i = 8'hA5;
      end
    end
    start_i = 1'b0;
    period_start_i = 1'b0;
    check(fin, "R7 done reached", int'(fin), 1);
    check(loads == 32, "R2 load count", loads, 32);
    for (int a = 0; a < 256; a++) begin
      rd_addr_i = 8'(a);
      @(negedge clk);
      check(int'(rd_data_o) == exp_class(a, n), "R3 R4 R5 R6 R9 R10 result",
            int'(rd_data_o), exp_class(a, n));
    end
    check(done_o == 1'b1, "R7 done held", int'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    check(tap_load_o == 1'b0, "R1 load in reset", int'(tap_load_o), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    check(tap_load_o == 1'b0, "R1 load after reset", int'(tap_load_o), 0);
    check(tap_o == 5'd0, "R1 tap after reset", int'(tap_o), 0);
    run_sweep(2, 5, 1, 1'b1);   // R8 start injected mid sweep
    run_sweep(0, 3, 3, 1'b0);
    run_sweep(1, 0, 1, 1'b0);   // R9 zero repetitions acts as one
    run_sweep(3, 4, 2, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule